// File: doc/BRIEF.md
# Dual-Address I2C Slave Recognizer

This block listens to the SCL and SDA lines of an I2C bus as a slave. It finds START, repeated START and STOP conditions and shifts in the first byte that follows each START. It then compares the upper seven bits of that byte with two programmable slave addresses. Bit 0 of each address register is a format bit. Taken together, the two format bits decide which addresses are honoured. They can also switch the interface into a synchronous serial format, which has no addressing. On a hit the block raises a one-cycle match pulse, reports which address matched and the received R/W bit, and pulls SDA low for the acknowledge clock. On a miss it leaves the bus alone until the next START.

Software reaches the registers through a small word port whose reads are combinational. There are no data streams, so the block has no valid/ready handshake and no back-pressure. The match report is a plain pulse that the consumer must take in the cycle it appears.

Top module: `i2c_dual_addr_slave`

## Requirements
- R1: After reset the first address register reads 0x00 at register address 0, the shared location at register address 1 reads 0x01, the control register at register address 2 reads 0x00 (bit 0 = enable), and sda_oe and match_valid are low.
- R2: The upper seven bits of the first byte after a START are compared with bits 7..1 of each address register, and bit 0 of that byte is reported on match_rw.
- R3: With both format bits 0, either address is recognized.
- R4: With the first format bit 0 and the second format bit 1, only the first address is recognized.
- R5: With the first format bit 1 and the second format bit 0, only the second address is recognized.
- R6: With both format bits 1 (synchronous serial format), no address is recognized and no acknowledge is driven.
- R7: A hit produces a match_valid pulse exactly one clock long. match_second is 0 for the first address and 1 for the second. If both addresses match, the first address wins.
- R8: On a hit, sda_oe goes high after the eighth SCL falling edge and stays high through the ninth SCL high period, so SDA reads low there. It is released after the ninth falling edge.
- R9: While enable is 0, register address 1 reads and writes the second address register. While enable is 1, the same address reads and writes a data register, which also captures each matched address byte, and a write there leaves the second address unchanged.
- R10: On a miss, no acknowledge is driven and the bus is ignored until a START. A repeated START begins a new address byte.
- R11: A STOP before the eighth bit returns the block to idle with no match reported.
- R12: While enable is 0, nothing is recognized and SDA is never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| reg_addr | input | 2 | Register address: 0 first address, 1 shared, 2 control |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| match_valid | output | 1 | One-cycle address hit pulse |
| match_second | output | 1 | 1 when the second address hit |
| match_rw | output | 1 | R/W bit of the matched byte |

## Verification
Each line passes through two synchronizer flops before it reaches the one-cycle edge detector, and the receiver registers its result on the next edge. The match pulse therefore appears three clocks after the eighth SCL rise at the pins. The acknowledge drive changes three clocks after the eighth and ninth SCL falls. The bench holds every SCL phase for eight clocks and reads SDA at the middle of the ninth high phase, well after the drive has settled. It counts match pulses on the falling clock edge over the whole transaction instead of at one fixed cycle. Register reads are combinational and are sampled one time unit after the address is set at a falling edge.

// File: rtl/dasl_pkg.sv
package dasl_pkg;
  localparam int WORD_W = 8;
  localparam int ADR_W  = WORD_W - 1;
  localparam int RA_W   = 2;
  localparam int CNT_W  = $clog2(WORD_W);

  localparam logic [RA_W-1:0] RA_ADR0   = 2'd0;
  localparam logic [RA_W-1:0] RA_SHARED = 2'd1;
  localparam logic [RA_W-1:0] RA_CTRL   = 2'd2;

  localparam logic [WORD_W-1:0] ADR0_RST = 8'h00;
  localparam logic [WORD_W-1:0] ADR1_RST = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ACK_WAIT,
    ST_ACK_DRIVE,
    ST_SKIP
  } rx_state_t;
endpackage

// File: rtl/dasl_line_sync.sv
module dasl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA moving while SCL stays high marks bus conditions
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/dasl_regs.sv
module dasl_regs
  import dasl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic              reg_we,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              cap_we,
  input  logic [WORD_W-1:0] cap_byte,
  output logic              en,
  output logic [WORD_W-1:0] adr0,
  output logic [WORD_W-1:0] adr1
);
  logic [WORD_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr0   <= ADR0_RST;
      adr1   <= ADR1_RST;
      en     <= 1'b0;
      data_q <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          RA_ADR0:   adr0 <= reg_wdata;
          RA_SHARED: begin
            if (!en) adr1   <= reg_wdata;
            else     data_q <= reg_wdata;
          end
          RA_CTRL:   en <= reg_wdata[0];
          default:   ;
        endcase
      end
      // a captured address byte takes precedence over software
      if (cap_we) data_q <= cap_byte;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_ADR0:   reg_rdata = adr0;
      RA_SHARED: reg_rdata = en ? data_q : adr1;
      RA_CTRL:   reg_rdata = {{(WORD_W-1){1'b0}}, en};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dasl_addr_rx.sv
module dasl_addr_rx
  import dasl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [WORD_W-1:0] adr0,
  input  logic [WORD_W-1:0] adr1,
  output logic              sda_oe,
  output logic              match_valid,
  output logic              match_second,
  output logic              match_rw,
  output logic              cap_we,
  output logic [WORD_W-1:0] cap_byte
);
  rx_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] byte_next;
  logic              hit0, hit1;

  assign byte_next = {shreg[WORD_W-2:0], sda_s};
  // a set format bit masks its own address
  assign hit0 = (byte_next[WORD_W-1:1] == adr0[WORD_W-1:1]) & ~adr0[0];
  assign hit1 = (byte_next[WORD_W-1:1] == adr1[WORD_W-1:1]) & ~adr1[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      shreg        <= '0;
      sda_oe       <= 1'b0;
      match_valid  <= 1'b0;
      match_second <= 1'b0;
      match_rw     <= 1'b0;
    end else if (!en) begin
      state       <= ST_IDLE;
      sda_oe      <= 1'b0;
      match_valid <= 1'b0;
    end else begin
      match_valid <= 1'b0;
      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= ST_SHIFT;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_SHIFT: if (scl_rise) begin
            shreg <= byte_next;
            if (cnt == CNT_W'(WORD_W - 1)) begin
              if (hit0 | hit1) begin
                state        <= ST_ACK_WAIT;
                match_valid  <= 1'b1;
                match_second <= ~hit0;
                match_rw     <= byte_next[0];
              end else begin
                state <= ST_SKIP;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ACK_WAIT: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_ACK_DRIVE;
          end
          ST_ACK_DRIVE: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  assign cap_we   = match_valid;
  assign cap_byte = shreg;
endmodule

// File: rtl/i2c_dual_addr_slave.sv
module i2c_dual_addr_slave
  import dasl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic              reg_we,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              match_valid,
  output logic              match_second,
  output logic              match_rw
);
  logic              sda_s_w, scl_rise_w, scl_fall_w, start_w, stop_w;
  logic              en_w, cap_we_w;
  logic [WORD_W-1:0] adr0_w, adr1_w, cap_byte_w;

  dasl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s_w),
    .scl_rise  (scl_rise_w),
    .scl_fall  (scl_fall_w),
    .start_det (start_w),
    .stop_det  (stop_w)
  );

  dasl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cap_we    (cap_we_w),
    .cap_byte  (cap_byte_w),
    .en        (en_w),
    .adr0      (adr0_w),
    .adr1      (adr1_w)
  );

  dasl_addr_rx u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en_w),
    .scl_rise     (scl_rise_w),
    .scl_fall     (scl_fall_w),
    .sda_s        (sda_s_w),
    .start_det    (start_w),
    .stop_det     (stop_w),
    .adr0         (adr0_w),
    .adr1         (adr1_w),
    .sda_oe       (sda_oe),
    .match_valid  (match_valid),
    .match_second (match_second),
    .match_rw     (match_rw),
    .cap_we       (cap_we_w),
    .cap_byte     (cap_byte_w)
  );
endmodule

// File: rtl/dasl_checker.sv
module dasl_checker
  import dasl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              fs,
  input logic              fsx,
  input logic [WORD_W-1:0] adr1,
  input logic              sda_oe,
  input logic              match_valid,
  input logic              match_second
);
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |=> !match_valid); // R7

  AST_SERIAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |-> !($past(fs) && $past(fsx))); // R6

  AST_FIRST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (match_valid && !match_second) |-> !$past(fs)); // R5

  AST_SECOND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (match_valid && match_second) |-> !$past(fsx)); // R4

  AST_ADR1_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(adr1) |-> !$past(en)); // R9

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> (!sda_oe && !match_valid)); // R12
endmodule

bind i2c_dual_addr_slave dasl_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en_w),
  .fs           (adr0_w[0]),
  .fsx          (adr1_w[0]),
  .adr1         (adr1_w),
  .sda_oe       (sda_oe),
  .match_valid  (match_valid),
  .match_second (match_second)
);

// File: tb/i2c_dual_addr_slave_bench.sv
module i2c_dual_addr_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_bus;
  logic       sda_oe;
  logic [1:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       match_valid, match_second, match_rw;

  int n_checks = 0;
  int n_errors = 0;
  int n_match = 0;
  bit last_second, last_rw;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_dual_addr_slave u_i2c_dual_addr_slave (
    .clk (clk), .rst_n (rst_n), .scl_i (scl), .sda_i (sda_bus), .sda_oe (sda_oe),
    .reg_addr (reg_addr), .reg_we (reg_we), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata), .match_valid (match_valid),
    .match_second (match_second), .match_rw (match_rw)
  );

  always @(negedge clk) if (match_valid) begin
    n_match++;
    last_second = match_second;
    last_rw     = match_rw;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl = 1'b1;   wait_q();
    sda_m = 1'b0; wait_q();
    scl = 1'b0;   wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl = 1'b1;   wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wait_q();
      scl = 1'b1;   wait_q(); wait_q();
      scl = 1'b0;   wait_q();
    end
  endtask

  task automatic send_addr(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; wait_q();
    scl = 1'b1;   wait_q();
    acked = (sda_bus == 1'b0);
    wait_q();
    scl = 1'b0;   wait_q();
  endtask

  task automatic addr_txn(input logic [7:0] b, input bit exp_hit, input bit exp_second,
                          input string req);
    bit acked;
    n_match = 0;
    bus_start();
    send_addr(b, acked);
    bus_stop();
    check(n_match == int'(exp_hit), req, n_match, int'(exp_hit));
    check(acked == exp_hit, {req, " ack R8"}, int'(acked), int'(exp_hit));
    if (exp_hit) begin
      check(last_second == exp_second, {req, " which R7"}, int'(last_second), int'(exp_second));
      check(last_rw == b[0], {req, " rw R2"}, int'(last_rw), int'(b[0]));
    end
    check(sda_oe == 1'b0, {req, " released R8"}, int'(sda_oe), 0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    reg_read(2'd0, d); check(d == 8'h00, "R1 adr0", d, 8'h00);
    reg_read(2'd1, d); check(d == 8'h01, "R1 adr1", d, 8'h01);
    reg_read(2'd2, d); check(d == 8'h00, "R1 ctrl", d, 8'h00);
    check(sda_oe == 1'b0 && match_valid == 1'b0, "R1 outputs", {sda_oe, match_valid}, 0);
  endtask

  task automatic t_first_only();
    reg_write(2'd0, 8'h50);
    reg_write(2'd2, 8'h01);
    addr_txn(8'h51, 1'b1, 1'b0, "R4 first hit");
    addr_txn(8'h01, 1'b0, 1'b0, "R4 second masked");
    addr_txn(8'h52, 1'b0, 1'b0, "R2 upper bits differ");
  endtask

  task automatic t_both_and_shared();
    logic [7:0] d;
    reg_write(2'd2, 8'h00);
    reg_write(2'd1, 8'h60);
    reg_write(2'd2, 8'h01);
    addr_txn(8'h61, 1'b1, 1'b1, "R3 second hit");
    addr_txn(8'h50, 1'b1, 1'b0, "R3 first hit");
    reg_read(2'd1, d); check(d == 8'h50, "R9 data captured", d, 8'h50);
    reg_write(2'd1, 8'hAB);
    reg_read(2'd1, d); check(d == 8'hAB, "R9 data write", d, 8'hAB);
    reg_write(2'd2, 8'h00);
    reg_read(2'd1, d); check(d == 8'h60, "R9 adr1 untouched", d, 8'h60);
    reg_write(2'd1, 8'h50);
    reg_write(2'd2, 8'h01);
    addr_txn(8'h50, 1'b1, 1'b0, "R7 first wins");
  endtask

  task automatic t_second_only();
    reg_write(2'd2, 8'h00);
    reg_write(2'd0, 8'h51);
    reg_write(2'd1, 8'h60);
    reg_write(2'd2, 8'h01);
    addr_txn(8'h50, 1'b0, 1'b0, "R5 first masked");
    addr_txn(8'h61, 1'b1, 1'b1, "R5 second hit");
  endtask

  task automatic t_serial();
    reg_write(2'd2, 8'h00);
    reg_write(2'd1, 8'h61);
    reg_write(2'd2, 8'h01);
    addr_txn(8'h50, 1'b0, 1'b0, "R6 first ignored");
    addr_txn(8'h60, 1'b0, 1'b0, "R6 second ignored");
  endtask

  task automatic t_restart();
    bit a1, a2;
    reg_write(2'd0, 8'h50);
    n_match = 0;
    bus_start();
    send_addr(8'h20, a1);
    send_bits(8'h50, 3);
    bus_start();
    send_addr(8'h50, a2);
    bus_stop();
    check(a1 == 1'b0, "R10 miss no ack", int'(a1), 0);
    check(a2 == 1'b1, "R10 restart ack", int'(a2), 1);
    check(n_match == 1, "R10 one match", n_match, 1);
  endtask

  task automatic t_stop_abort();
    n_match = 0;
    bus_start();
    send_bits(8'h50, 4);
    bus_stop();
    check(n_match == 0, "R11 stop abort", n_match, 0);
    addr_txn(8'h50, 1'b1, 1'b0, "R11 after stop");
  endtask

  task automatic t_disabled();
    reg_write(2'd2, 8'h00);
    addr_txn(8'h50, 1'b0, 1'b0, "R12 disabled");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_first_only();
    t_both_and_shared();
    t_second_only();
    t_serial();
    t_restart();
    t_stop_abort();
    t_disabled();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule